// File: doc/BRIEF.md
# 8-bit ALU with Packed Flag Register

This block is the arithmetic and logic stage of a small 8-bit datapath. Each cycle the caller presents an accumulator value, a second operand and a 4-bit operation code with a valid strobe. The block returns the result combinationally, in the same cycle. It also raises a strobe when that result should be written back to the accumulator. The five condition flags are held in an internal register and update at the next rising clock edge. The stored carry flag feeds the carry-with and borrow-with operations.

The flags appear as one packed byte. The same byte can be loaded through a write port, for example to restore state after a context switch. Compare produces flags exactly like subtract but suppresses the write-back strobe. Increment and decrement preserve the carry flag. Rotates touch only the carry flag.

Top module: `alu8_flag_unit`

## Requirements
- R1: After reset is asserted, flags_o reads 8'h02.
- R2: flags_o packs sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2 and carry in bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1, whatever is written.
- R3: When flag_we_i is high at a rising edge, the five flags load from bits 7, 6, 4, 2 and 0 of flag_wdata_i. This write wins over an operation presented in the same cycle.
- R4: ADD (code 0) gives acc+opnd and ADC (code 1) gives acc+opnd+CY. CY is the carry out of bit 7, and AC is the carry from bit 3 into bit 4.
- R5: SUB (code 2) gives acc-opnd and SBB (code 3) gives acc-opnd-CY. CY is the borrow out of bit 7. AC is the carry out of bit 3 of acc + ~opnd + (1 - borrow_in).
- R6: CMP (code 4) sets all five flags as SUB does, and acc_we_o stays 0.
- R7: INC (code 5) gives acc+1 and DEC (code 6) gives acc-1; both ignore opnd. AC is set for INC when acc[3:0] is 4'hF, and for DEC when acc[3:0] is non-zero. CY is unchanged.
- R8: AND (7), OR (8) and XOR (9) combine acc and opnd and clear CY. AC becomes 1 for AND and 0 for OR and XOR.
- R9: The rotates act on acc alone: RLC (10) left with bit 7 into bit 0, RRC (11) right with bit 0 into bit 7, RAL (12) left through CY, RAR (13) right through CY. CY takes the bit shifted out, and S, Z, AC and P are unchanged.
- R10: For codes 0 to 9, S is result bit 7, Z is set when the result is zero, and P is set when the result has an even number of ones.
- R11: With op_valid_i low, or with codes 14 and 15, the flags do not change and acc_we_o is 0.
- R12: acc_we_o equals op_valid_i for codes 0-3 and 5-13 in the same cycle, and the flags take their new value at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flag_we_i | input | 1 | Load flag register from flag_wdata_i |
| flag_wdata_i | input | 8 | Packed flag byte to load |
| result_o | output | 8 | Operation result (difference for compare) |
| acc_we_o | output | 1 | Result should be written to the accumulator |
| flags_o | output | 8 | Packed flag byte |

## Verification
The bench builds the block with the default DATA_W of 8, the only width at which the nibble boundary for the auxiliary carry and the packed byte layout are defined. At this width, exhaustive boundary operands are cheap to pick by hand. These include the wrap to zero at 8'hFF+1, the borrow at equal and smaller operands, and the nibble edges 4'hF and 4'h0 for increment and decrement. They also include each rotate with both values of the incoming carry. Flag-write priority and the fixed bits are exercised by writing all-ones and all-zeros bytes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_CMP = 4'd4,  OP_INC = 4'd5,  OP_DEC = 4'd6,  OP_AND = 4'd7,
    OP_OR  = 4'd8,  OP_XOR = 4'd9,  OP_RLC = 4'd10, OP_RRC = 4'd11,
    OP_RAL = 4'd12, OP_RAR = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } alu_op_e;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_CY = 0;
  localparam logic [7:0] FLAG_FIXED = 8'h02;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              ci_i,   // carry in, or borrow in when sub_i
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              co_o,   // carry out, or borrow out when sub_i
  output logic              hc_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   full;
  logic [HALF_W:0]   low;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? ~ci_i : ci_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
    low   = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]} + {{HALF_W{1'b0}}, c_eff};
    sum_o = full[DATA_W-1:0];
    co_o  = sub_i ? ~full[DATA_W] : full[DATA_W];
    hc_o  = low[HALF_W];
  end
endmodule

// File: rtl/alu8_logic_rot.sv
module alu8_logic_rot
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  always_comb begin
    res_o = '0;
    cy_o  = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_RLC: begin res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]}; cy_o = a_i[DATA_W-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[DATA_W-1:1]};        cy_o = a_i[0];        end
      OP_RAL: begin res_o = {a_i[DATA_W-2:0], cy_i};          cy_o = a_i[DATA_W-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[DATA_W-1:1]};          cy_o = a_i[0];        end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  flags_t     nxt_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output flags_t     q_o,
  output logic [7:0] byte_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (we_i) begin
      q <= '{s: wdata_i[FB_S], z: wdata_i[FB_Z], ac: wdata_i[FB_AC],
             p: wdata_i[FB_P], cy: wdata_i[FB_CY]};
    end else if (upd_i) begin
      q <= nxt_i;
    end
  end

  always_comb begin
    byte_o        = FLAG_FIXED;
    byte_o[FB_S]  = q.s;
    byte_o[FB_Z]  = q.z;
    byte_o[FB_AC] = q.ac;
    byte_o[FB_P]  = q.p;
    byte_o[FB_CY] = q.cy;
  end

  assign q_o = q;
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              flag_we_i,
  input  logic [7:0]        flag_wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic [7:0]        flags_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  alu_op_e op;
  flags_t  cur, nxt;
  logic    upd;

  logic [DATA_W-1:0] as_b, as_sum, lr_res;
  logic              as_ci, as_sub, as_co, as_hc, lr_cy;

  assign op = alu_op_e'(op_i);

  always_comb begin
    as_b   = opnd_i;
    as_ci  = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_ADC:         as_ci = cur.cy;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB:         begin as_sub = 1'b1; as_ci = cur.cy; end
      OP_INC:         as_b = ONE;
      OP_DEC:         begin as_b = ONE; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i  (acc_i),
    .b_i  (as_b),
    .ci_i (as_ci),
    .sub_i(as_sub),
    .sum_o(as_sum),
    .co_o (as_co),
    .hc_o (as_hc)
  );

  alu8_logic_rot #(.DATA_W(DATA_W)) u_logic_rot (
    .op_i (op),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .cy_i (cur.cy),
    .res_o(lr_res),
    .cy_o (lr_cy)
  );

  always_comb begin
    result_o = as_sum;
    acc_we_o = op_valid_i;
    upd      = op_valid_i;
    nxt      = cur;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        nxt.cy = as_co;
        nxt.ac = as_hc;
      end
      OP_INC, OP_DEC: nxt.ac = as_hc;
      OP_AND, OP_OR, OP_XOR: begin
        result_o = lr_res;
        nxt.cy   = 1'b0;
        nxt.ac   = (op == OP_AND);
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        result_o = lr_res;
        nxt.cy   = lr_cy;
      end
      default: begin
        acc_we_o = 1'b0;
        upd      = 1'b0;
      end
    endcase
    if (op == OP_CMP) acc_we_o = 1'b0;
    if (!(op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR})) begin
      nxt.s = result_o[DATA_W-1];
      nxt.z = (result_o == '0);
      nxt.p = ~^result_o;
    end
  end

  alu8_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .nxt_i  (nxt),
    .we_i   (flag_we_i),
    .wdata_i(flag_wdata_i),
    .q_o    (cur),
    .byte_o (flags_o)
  );
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [3:0]        op_i,
  input logic              flag_we_i,
  input logic [DATA_W-1:0] result_o,
  input logic              acc_we_o,
  input logic [7:0]        flags_o
);
  logic is_rot, is_logic, is_incdec, is_live;
  assign is_rot    = op_i inside {4'd10, 4'd11, 4'd12, 4'd13};
  assign is_logic  = op_i inside {4'd7, 4'd8, 4'd9};
  assign is_incdec = op_i inside {4'd5, 4'd6};
  assign is_live   = op_valid_i && !flag_we_i;

  a_r2_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b1);

  a_r6_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'd4) |-> !acc_we_o);

  a_r7_incdec_keeps_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_live && is_incdec) |=> flags_o[0] == $past(flags_o[0]));

  a_r8_logic_clears_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_live && is_logic) |=> flags_o[0] == 1'b0);

  a_r9_rot_keeps_szap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_live && is_rot) |=> flags_o[7:1] == $past(flags_o[7:1]));

  a_r10_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_live && op_i <= 4'd9) |=> flags_o[6] == ($past(result_o) == '0));

  a_r11_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && (!op_valid_i || op_i >= 4'd14)) |=> $stable(flags_o));

  a_r11_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i || op_i >= 4'd14) |-> !acc_we_o);
endmodule

bind alu8_flag_unit alu8_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_alu8_flag_unit.sv
`timescale 1ns/1ps
module sim_alu8_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0, opnd = '0;
  logic       flag_we = 1'b0;
  logic [7:0] flag_wdata = '0;
  logic [7:0] result, flags;
  logic       acc_we;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_f;

  always #2.5 clk = ~clk;

  alu8_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .acc_i(acc), .opnd_i(opnd), .flag_we_i(flag_we), .flag_wdata_i(flag_wdata),
    .result_o(result), .acc_we_o(acc_we), .flags_o(flags)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // returns {we, result, flags}
  function automatic logic [16:0] model(logic [3:0] o, logic [7:0] a, logic [7:0] b, logic [7:0] f);
    logic cy, ncy, nac, we;
    logic [7:0] r;
    logic [8:0] t;
    logic [4:0] h;
    logic bi;
    cy = f[0]; ncy = cy; nac = 1'b0; r = 8'h00; we = 1'b1;
    case (o)
      4'd0, 4'd1: begin
        bi = (o == 4'd1) ? cy : 1'b0;
        t = {1'b0, a} + {1'b0, b} + {8'd0, bi};
        h = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, bi};
        r = t[7:0]; ncy = t[8]; nac = h[4];
      end
      4'd2, 4'd3, 4'd4: begin
        bi = (o == 4'd3) ? cy : 1'b0;
        t = {1'b0, a} - {1'b0, b} - {8'd0, bi};
        h = {1'b0, a[3:0]} + {1'b0, ~b[3:0]} + {4'd0, ~bi};
        r = t[7:0]; ncy = t[8]; nac = h[4];
        if (o == 4'd4) we = 1'b0;
      end
      4'd5: begin r = a + 8'd1; nac = (a[3:0] == 4'hF); end
      4'd6: begin r = a - 8'd1; nac = (a[3:0] != 4'h0); end
      4'd7: begin r = a & b; ncy = 1'b0; nac = 1'b1; end
      4'd8: begin r = a | b; ncy = 1'b0; end
      4'd9: begin r = a ^ b; ncy = 1'b0; end
      4'd10: begin r = {a[6:0], a[7]}; ncy = a[7]; end
      4'd11: begin r = {a[0], a[7:1]}; ncy = a[0]; end
      4'd12: begin r = {a[6:0], cy};   ncy = a[7]; end
      4'd13: begin r = {cy, a[7:1]};   ncy = a[0]; end
      default: we = 1'b0;
    endcase
    if (o >= 4'd14) return {1'b0, 8'h00, f};
    if (o >= 4'd10) return {we, r, {f[7], f[6], 1'b0, f[4], 1'b0, f[2], 1'b1, ncy}};
    return {we, r, {r[7], r == 8'h00, 1'b0, nac, 1'b0, ~^r, 1'b1, ncy}};
  endfunction

  task automatic do_op(string req, logic [3:0] o, logic [7:0] a, logic [7:0] b);
    logic [16:0] m;
    @(negedge clk);
    op = o; acc = a; opnd = b; op_valid = 1'b1;
    m = model(o, a, b, exp_f);
    #1;
    check8({req, " acc_we"}, {7'd0, acc_we}, {7'd0, m[16]});
    if (m[16]) check8({req, " result"}, result, m[15:8]);
    @(posedge clk); #1;
    op_valid = 1'b0;
    exp_f = m[7:0];
    check8({req, " flags"}, flags, exp_f);
  endtask

  task automatic write_flags(string req, logic [7:0] w, logic also_op);
    @(negedge clk);
    flag_we = 1'b1; flag_wdata = w;
    if (also_op) begin op = 4'd0; acc = 8'hFF; opnd = 8'h01; op_valid = 1'b1; end
    @(posedge clk); #1;
    flag_we = 1'b0; op_valid = 1'b0;
    exp_f = (w & 8'hD5) | 8'h02;
    check8(req, flags, exp_f);
  endtask

  task automatic t_reset;
    check8("R1 reset flags", flags, 8'h02);
    exp_f = 8'h02;
  endtask

  task automatic t_add;
    do_op("R4 add wrap", 4'd0, 8'h3A, 8'hC6);
    do_op("R4 add half", 4'd0, 8'h0F, 8'h01);
    do_op("R4 adc cy0", 4'd1, 8'h7F, 8'h00);
    do_op("R4 adc setup", 4'd0, 8'hFF, 8'h02);
    do_op("R4 adc cy1", 4'd1, 8'h10, 8'h20);
    do_op("R10 add sign", 4'd0, 8'h40, 8'h40);
  endtask

  task automatic t_sub;
    do_op("R5 sub borrow", 4'd2, 8'h05, 8'h07);
    do_op("R5 sbb bin1", 4'd3, 8'h10, 8'h01);
    do_op("R5 sbb bin0", 4'd3, 8'h10, 8'h01);
    do_op("R5 sub zero", 4'd2, 8'h80, 8'h80);
  endtask

  task automatic t_cmp;
    do_op("R6 cmp eq", 4'd4, 8'h55, 8'h55);
    do_op("R6 cmp lt", 4'd4, 8'h12, 8'h34);
    do_op("R6 cmp gt", 4'd4, 8'h90, 8'h01);
  endtask

  task automatic t_incdec;
    write_flags("R3 set cy", 8'h01, 1'b0);
    do_op("R7 inc wrap", 4'd5, 8'hFF, 8'hAA);
    do_op("R7 inc half", 4'd5, 8'h2F, 8'h00);
    do_op("R7 dec nib0", 4'd6, 8'h10, 8'h00);
    do_op("R7 dec one", 4'd6, 8'h01, 8'h77);
  endtask

  task automatic t_logic;
    write_flags("R3 set cy2", 8'h01, 1'b0);
    do_op("R8 and", 4'd7, 8'hF0, 8'h3C);
    do_op("R8 and zero", 4'd7, 8'hF0, 8'h0F);
    do_op("R8 or", 4'd8, 8'h01, 8'h80);
    do_op("R8 xor", 4'd9, 8'hA5, 8'hA5);
  endtask

  task automatic t_rot;
    write_flags("R3 mix", 8'hD4, 1'b0);
    do_op("R9 rlc", 4'd10, 8'h81, 8'h00);
    do_op("R9 rrc", 4'd11, 8'h02, 8'h00);
    do_op("R9 ral cy0", 4'd12, 8'h40, 8'h00);
    do_op("R9 ral cy0b", 4'd12, 8'h80, 8'h00);
    do_op("R9 ral cy1", 4'd12, 8'h00, 8'h00);
    do_op("R9 rar cy0", 4'd13, 8'h01, 8'h00);
    do_op("R9 rar cy1", 4'd13, 8'h00, 8'h00);
  endtask

  task automatic t_flag_write;
    write_flags("R2 write ones", 8'hFF, 1'b0);
    check8("R2 fixed bits ones", flags & 8'h2A, 8'h02);
    write_flags("R2 write zeros", 8'h00, 1'b0);
    write_flags("R3 priority", 8'h80, 1'b1);
  endtask

  task automatic t_idle;
    write_flags("R11 setup", 8'hC5, 1'b0);
    do_op("R11 code14", 4'd14, 8'h00, 8'h00);
    do_op("R11 code15", 4'd15, 8'hFF, 8'hFF);
    @(negedge clk);
    op = 4'd0; acc = 8'hFF; opnd = 8'h01; op_valid = 1'b0;
    #1 check8("R12 no valid acc_we", {7'd0, acc_we}, 8'h00);
    @(posedge clk); #1;
    check8("R11 no valid flags", flags, exp_f);
    @(negedge clk);
    op_valid = 1'b1;
    #1 check8("R12 same-cycle acc_we", {7'd0, acc_we}, 8'h01);
    check8("R12 flags before edge", flags, exp_f);
    @(posedge clk); #1;
    op_valid = 1'b0;
    check8("R12 flags after edge", flags, 8'h57);
    exp_f = 8'h57;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #12 t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_add();
    t_sub();
    t_cmp();
    t_incdec();
    t_logic();
    t_rot();
    t_flag_write();
    t_idle();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule